// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Protocol Engine

This block is the bus-facing controller of an 8192-byte serial EEPROM. It oversamples the two-wire bus (clock and data) on a fast system clock and drives the data line as an open drain through a single pull-low enable. It detects start and stop conditions and checks the device-select byte against three strap pins. It then takes in a two-byte word address and, depending on the direction bit, either passes received bytes to a page-write unit or streams bytes fetched from a synchronous memory read port.

A 13-bit address pointer lives across transactions. Writes advance only the low six bits, so a burst stays inside one 64-byte page. Reads advance the whole pointer and wrap from the last location to zero. This supports current-address, random (a dummy write followed by a repeated start) and sequential reads. While the external program cycle reports busy, the engine leaves its own address unacknowledged so the host can poll. When write protection is on, the first data byte aimed at the locked quarter of the array is refused.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the data line is released, no write strobe or commit pulse is produced, and the address pointer is 0, so a current-address read returns location 0.
- R2: The engine acknowledges a select byte only if bits 7..4 equal 1010 and bits 3..1 equal `strap_i` (bit 0 = 1 selects read, 0 selects write). On a mismatch it gives no acknowledge, ignores every following byte until the next start, and leaves the pointer unchanged.
- R3: An accepted byte is acknowledged by pulling the data line low during the ninth clock. The pull-low enable only changes while the synchronized clock line is low.
- R4: In a write, the two bytes after the select byte form the word address, high byte first, with bits 7..5 of the high byte ignored. Each accepted data byte produces one single-cycle `wr_valid_o` carrying `wr_addr_o` and `wr_data_o`.
- R5: Within one write, each further data byte goes to the previous address with its low 6 bits incremented modulo 64 and bits 12..6 unchanged.
- R6: A stop that ends a transaction with at least one accepted data byte produces a single-cycle `wr_commit_o` one cycle after the stop is detected. A stop after a write with no data byte (such as a dummy write) produces none.
- R7: While `busy_i` is high the select byte is not acknowledged, and no address or data is taken.
- R8: With `wp_i` high and the pointer in the locked quarter (bits 12..11 = 00 by default, 11 when `PROT_TOP` = 1), the select byte and both address bytes are still acknowledged. The first data byte is not acknowledged, no write strobe or commit follows, and the memory keeps its contents. Writes outside that quarter are accepted.
- R9: A current-address read returns the byte at the pointer. Each byte sent advances the pointer by one across all 13 bits, wrapping from 8191 to 0. A write leaves the pointer one past the last written location (page-wrapped).
- R10: A random read (select write, two address bytes, repeated start, select read) returns the byte at the given address.
- R11: In a read, the engine sends 8 bits with the most significant bit first, then releases the line and samples the master's acknowledge. An acknowledge makes it send the next byte. A no-acknowledge makes it stop driving until the next start or stop.
- R12: A start is recognized in any state, including partway through a byte, and restarts select-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved) |
| sda_oe_o | output | 1 | 1 = pull data line low |
| strap_i | input | 3 | Device-select strap value |
| busy_i | input | 1 | Program cycle in progress |
| wp_i | input | 1 | Write protect active |
| rd_addr_o | output | 13 | Memory read address (current pointer) |
| rd_data_i | input | 8 | Memory read data, one clock after address |
| wr_valid_o | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr_o | output | 13 | Address of the accepted write byte |
| wr_data_o | output | 8 | Accepted write byte |
| wr_commit_o | output | 1 | One-cycle pulse: stop ended a write with data |

## Verification
The engine is driven by a bit-level bus master with a shared open-drain line. The traffic includes single-byte and page-wrapping multi-byte writes, current, random and sequential reads, and reads crossing the top of the address space. Mismatched select bytes and select bytes sent while busy tell a correct filter apart from one that acknowledges too much or lets ignored bytes move the pointer. Protected and unprotected writes under write protect tell quarter decoding apart from a blanket refusal. A start partway through a byte, and clocks sent after a read no-acknowledge, show whether the framing state is truly reset and the line truly released.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    localparam int DATA_W      = 8;
    localparam int STRAP_W     = 3;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } slv_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic dev_match(input logic [DATA_W-1:0] sel,
                                       input logic [STRAP_W-1:0] strap);
        return (sel[DATA_W-1 -: 4] == DEV_TYPE) && (sel[STRAP_W:1] == strap);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import eeprom_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    always_comb begin
        evt_o.scl   = scl_s;
        evt_o.sda   = sda_s;
        evt_o.rise  = scl_s & ~scl_d;
        evt_o.fall  = ~scl_s & scl_d;
        // data edges while the clock stays high frame a transaction
        evt_o.start = scl_s & scl_d & sda_d & ~sda_s;
        evt_o.stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/eeprom_word_pointer.sv
module eeprom_word_pointer
    import eeprom_i2c_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PAGE_BITS = 6,
    parameter bit PROT_TOP  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    input  logic              step_page_i,
    input  logic              step_linear_i,
    input  logic              wp_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              locked_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [1:0]        quarter;
    logic              in_region;
    logic              unused_hi_bits;

    assign unused_hi_bits = ^rx_byte_i[DATA_W-1:HI_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            ptr_q <= '0;
        end else begin
            if (ld_hi_i)
                hi_q <= rx_byte_i[HI_W-1:0];
            if (ld_lo_i)
                ptr_q <= {hi_q, rx_byte_i};
            else if (step_page_i)
                ptr_q <= {ptr_q[ADDR_W-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + 1'b1};
            else if (step_linear_i)
                ptr_q <= ptr_q + 1'b1;
        end
    end

    assign quarter = ptr_q[ADDR_W-1 -: 2];

    generate
        if (PROT_TOP) begin : g_lock_top
            assign in_region = &quarter;
        end else begin : g_lock_bottom
            assign in_region = ~|quarter;
        end
    endgenerate

    assign ptr_o    = ptr_q;
    assign locked_o = wp_i & in_region;

endmodule

// File: rtl/eeprom_i2c_proto.sv
module eeprom_i2c_proto
    import eeprom_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           evt_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic               locked_i,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               sda_oe_o,
    output logic [DATA_W-1:0]  rx_byte_o,
    output logic               ld_hi_o,
    output logic               ld_lo_o,
    output logic               step_page_o,
    output logic               step_linear_o,
    output logic               wr_valid_o,
    output logic [DATA_W-1:0]  wr_data_o,
    output logic               wr_commit_o
);

    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(DATA_W + 1);

    slv_state_t        state;
    slv_state_t        next_st;
    logic [CNT_W-1:0]  bitcnt;
    logic              ack_phase;
    logic [DATA_W-1:0] shreg;
    logic              first_data;
    logic              any_wr;
    logic              mack;
    logic              dev_hit;
    logic              unused_scl;

    assign unused_scl = evt_i.scl;
    assign dev_hit    = dev_match(shreg, strap_i) && !busy_i;
    assign rx_byte_o  = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            next_st       <= ST_IDLE;
            bitcnt        <= '0;
            ack_phase     <= 1'b0;
            shreg         <= '0;
            first_data    <= 1'b0;
            any_wr        <= 1'b0;
            mack          <= 1'b0;
            sda_oe_o      <= 1'b0;
            ld_hi_o       <= 1'b0;
            ld_lo_o       <= 1'b0;
            step_page_o   <= 1'b0;
            step_linear_o <= 1'b0;
            wr_valid_o    <= 1'b0;
            wr_data_o     <= '0;
            wr_commit_o   <= 1'b0;
        end else begin
            ld_hi_o       <= 1'b0;
            ld_lo_o       <= 1'b0;
            step_page_o   <= 1'b0;
            step_linear_o <= 1'b0;
            wr_valid_o    <= 1'b0;
            wr_commit_o   <= 1'b0;

            if (evt_i.start) begin
                state     <= ST_DEV;
                bitcnt    <= '0;
                ack_phase <= 1'b0;
                sda_oe_o  <= 1'b0;
            end else if (evt_i.stop) begin
                state       <= ST_IDLE;
                bitcnt      <= '0;
                ack_phase   <= 1'b0;
                sda_oe_o    <= 1'b0;
                wr_commit_o <= any_wr;
                any_wr      <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                    end

                    ST_RDAT: begin
                        if (evt_i.rise && bitcnt == ACK_SLOT) begin
                            mack          <= ~evt_i.sda;
                            step_linear_o <= 1'b1;
                        end
                        if (evt_i.fall) begin
                            if (bitcnt < BYTE_BITS) begin
                                sda_oe_o <= ~shreg[DATA_W-1];
                                shreg    <= {shreg[DATA_W-2:0], 1'b0};
                                bitcnt   <= bitcnt + 1'b1;
                            end else if (bitcnt == BYTE_BITS) begin
                                sda_oe_o <= 1'b0;
                                bitcnt   <= ACK_SLOT;
                            end else if (mack) begin
                                sda_oe_o <= ~rd_data_i[DATA_W-1];
                                shreg    <= {rd_data_i[DATA_W-2:0], 1'b0};
                                bitcnt   <= CNT_W'(1);
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_IDLE;
                            end
                        end
                    end

                    default: begin
                        if (evt_i.rise && bitcnt < BYTE_BITS) begin
                            shreg  <= {shreg[DATA_W-2:0], evt_i.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (evt_i.fall && ack_phase) begin
                            ack_phase <= 1'b0;
                            bitcnt    <= '0;
                            state     <= next_st;
                            if (next_st == ST_RDAT) begin
                                sda_oe_o <= ~rd_data_i[DATA_W-1];
                                shreg    <= {rd_data_i[DATA_W-2:0], 1'b0};
                                bitcnt   <= CNT_W'(1);
                            end else begin
                                sda_oe_o <= 1'b0;
                            end
                        end else if (evt_i.fall && bitcnt == BYTE_BITS) begin
                            case (state)
                                ST_DEV: begin
                                    if (dev_hit) begin
                                        sda_oe_o  <= 1'b1;
                                        ack_phase <= 1'b1;
                                        next_st   <= shreg[0] ? ST_RDAT : ST_AHI;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                ST_AHI: begin
                                    sda_oe_o  <= 1'b1;
                                    ack_phase <= 1'b1;
                                    ld_hi_o   <= 1'b1;
                                    next_st   <= ST_ALO;
                                end
                                ST_ALO: begin
                                    sda_oe_o   <= 1'b1;
                                    ack_phase  <= 1'b1;
                                    ld_lo_o    <= 1'b1;
                                    first_data <= 1'b1;
                                    next_st    <= ST_WDAT;
                                end
                                default: begin
                                    if (first_data && locked_i) begin
                                        state <= ST_IDLE;
                                    end else begin
                                        sda_oe_o    <= 1'b1;
                                        ack_phase   <= 1'b1;
                                        wr_valid_o  <= 1'b1;
                                        wr_data_o   <= shreg;
                                        step_page_o <= 1'b1;
                                        any_wr      <= 1'b1;
                                        first_data  <= 1'b0;
                                        next_st     <= ST_WDAT;
                                    end
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eeprom_i2c_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BITS   = 6,
    parameter int SYNC_STAGES = 2,
    parameter bit PROT_TOP    = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic               wp_i,
    output logic [ADDR_W-1:0]  rd_addr_o,
    input  logic [DATA_W-1:0]  rd_data_i,
    output logic               wr_valid_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0]  wr_data_o,
    output logic               wr_commit_o
);

    bus_evt_t          bus_evt;
    logic [DATA_W-1:0] rx_byte;
    logic              ld_hi;
    logic              ld_lo;
    logic              step_page;
    logic              step_linear;
    logic              locked;
    logic [ADDR_W-1:0] ptr;
    logic              scl_lvl;
    logic              start_det;
    logic              stop_det;

    assign scl_lvl   = bus_evt.scl;
    assign start_det = bus_evt.start;
    assign stop_det  = bus_evt.stop;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (bus_evt)
    );

    eeprom_word_pointer #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .PROT_TOP  (PROT_TOP)
    ) u_ptr (
        .clk           (clk),
        .rst           (rst),
        .rx_byte_i     (rx_byte),
        .ld_hi_i       (ld_hi),
        .ld_lo_i       (ld_lo),
        .step_page_i   (step_page),
        .step_linear_i (step_linear),
        .wp_i          (wp_i),
        .ptr_o         (ptr),
        .locked_o      (locked)
    );

    eeprom_i2c_proto u_proto (
        .clk           (clk),
        .rst           (rst),
        .evt_i         (bus_evt),
        .strap_i       (strap_i),
        .busy_i        (busy_i),
        .locked_i      (locked),
        .rd_data_i     (rd_data_i),
        .sda_oe_o      (sda_oe_o),
        .rx_byte_o     (rx_byte),
        .ld_hi_o       (ld_hi),
        .ld_lo_o       (ld_lo),
        .step_page_o   (step_page),
        .step_linear_o (step_linear),
        .wr_valid_o    (wr_valid_o),
        .wr_data_o     (wr_data_o),
        .wr_commit_o   (wr_commit_o)
    );

    assign rd_addr_o = ptr;
    assign wr_addr_o = ptr;

endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk #(
    parameter int ADDR_W    = 13,
    parameter int PAGE_BITS = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_commit,
    input logic              scl_lvl,
    input logic              start_det,
    input logic              stop_det
);

    logic              seen_wr;
    logic [ADDR_W-1:0] last_wr;
    logic [ADDR_W-1:0] exp_next;

    always_ff @(posedge clk) begin
        if (rst || start_det || stop_det) begin
            seen_wr <= 1'b0;
            last_wr <= '0;
        end else if (wr_valid) begin
            seen_wr <= 1'b1;
            last_wr <= wr_addr;
        end
    end

    assign exp_next = {last_wr[ADDR_W-1:PAGE_BITS], last_wr[PAGE_BITS-1:0] + 1'b1};

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_oe && !wr_valid && !wr_commit));

    // R3: drive only changes with the clock line low
    a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R4: write strobe lasts one cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R5: later bytes of one write step within the page
    a_r5_page_step: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && seen_wr) |-> (wr_addr == exp_next));

    // R6: commit only follows a stop
    a_r6_commit_after_stop: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(stop_det));

endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe_o),
    .wr_valid  (wr_valid_o),
    .wr_addr   (wr_addr_o),
    .wr_commit (wr_commit_o),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/eeprom_i2c_slave_tb.sv
module eeprom_i2c_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam logic [2:0] STRAP = 3'b101;

    typedef struct {
        logic [12:0] a;
        logic [7:0]  d;
        string       tag;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        busy = 1'b0;
    logic        wp = 1'b0;
    logic [12:0] rd_addr;
    logic [7:0]  rd_data = 8'h00;
    logic        wr_valid;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_commit;
    wire         sda_line = sda_m & ~sda_oe;

    logic [7:0]  mem [0:8191];
    wr_item_t    exp_q[$];
    wr_item_t    it;
    int          checks = 0;
    int          failures = 0;
    int          commits = 0;
    int          wr_seen = 0;
    int          oe_rises = 0;
    int          oe_bad = 0;
    logic        prev_oe = 1'b0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_i2c_slave u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_i     (STRAP),
        .busy_i      (busy),
        .wp_i        (wp),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .wr_valid_o  (wr_valid),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit)
    );

    // memory model: synchronous read port, write strobe stores directly
    always @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (wr_valid) mem[wr_addr] <= wr_data;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                wr_seen++;
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R4 unexpected write actual=%0h:%0h expected=none", wr_addr, wr_data);
                end else begin
                    it = exp_q.pop_front();
                    chk({it.tag, " write address"}, int'(wr_addr), int'(it.a));
                    chk({it.tag, " write data"}, int'(wr_data), int'(it.d));
                end
            end
            if (wr_commit) commits++;
            if (sda_oe && !prev_oe) oe_rises++;
            if ((sda_oe != prev_oe) && scl_m) oe_bad++;
            prev_oe = sda_oe;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {4'b1010, STRAP, rw};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = mack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic begin_write(input logic [15:0] a, input string req);
        logic k;
        bus_start();
        put_byte(dev(1'b0), k); chk({req, " select ack"}, k, 1);
        put_byte(a[15:8], k);   chk({req, " high address ack"}, k, 1);
        put_byte(a[7:0], k);    chk({req, " low address ack"}, k, 1);
    endtask

    task automatic cur_read(input logic [12:0] exp_a, input string req);
        logic k;
        logic [7:0] b;
        bus_start();
        put_byte(dev(1'b1), k);
        chk({req, " read select ack"}, k, 1);
        get_byte(1'b0, b);
        bus_stop();
        chk({req, " current read data"}, b, mem[exp_a]);
    endtask

    task automatic rand_read(input logic [15:0] a, output logic [7:0] b, input string req);
        logic k;
        begin_write(a, req);
        bus_start();
        put_byte(dev(1'b1), k);
        chk({req, " repeated-start select ack"}, k, 1);
        get_byte(1'b0, b);
        bus_stop();
    endtask

    task automatic push_wr(input logic [12:0] a, input logic [7:0] d, input string tag);
        wr_item_t e;
        e.a = a; e.d = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic k;
        logic [7:0] b;
        int c0;
        int r0;
        int w0;
        logic [7:0] orig;

        for (int i = 0; i < 8192; i++) mem[i] = 8'(i * 37 + 11) ^ 8'(i >> 5);
        tick(5);
        rst = 1'b0;
        tick(2);

        // R1: quiet outputs after reset
        chk("R1 data line released", sda_oe, 0);
        chk("R1 no write strobe", wr_valid, 0);
        chk("R1 no commit", wr_commit, 0);
        // R1 / R9: pointer starts at 0
        cur_read(13'h0000, "R1");

        // R2: wrong strap gets no ack, later bytes ignored, pointer kept
        bus_start();
        put_byte({4'b1010, STRAP ^ 3'b011, 1'b1}, k);
        chk("R2 mismatch no ack", k, 0);
        r0 = oe_rises;
        put_byte(dev(1'b0), k);
        chk("R2 ignored byte no ack", k, 0);
        chk("R2 no drive while ignored", oe_rises - r0, 0);
        bus_stop();
        put_byte(8'hA1, k);
        chk("R2 wrong type after stop no ack", k, 0);
        cur_read(13'h0001, "R2");

        // R4 / R6: single byte write, top address bits ignored
        c0 = commits;
        begin_write(16'hE123, "R4");
        push_wr(13'h0123, 8'h5A, "R4");
        put_byte(8'h5A, k);
        chk("R3 data ack on ninth clock", k, 1);
        bus_stop();
        tick(4);
        chk("R6 commit after write stop", commits - c0, 1);

        // R7: busy blocks select ack
        busy = 1'b1;
        c0 = commits;
        w0 = wr_seen;
        bus_start();
        put_byte(dev(1'b0), k);
        chk("R7 no ack while busy", k, 0);
        put_byte(8'h00, k);
        chk("R7 address byte ignored while busy", k, 0);
        bus_stop();
        tick(4);
        chk("R7 no write while busy", wr_seen - w0, 0);
        chk("R7 no commit while busy", commits - c0, 0);
        busy = 1'b0;
        bus_start();
        put_byte(dev(1'b0), k);
        chk("R7 ack once idle", k, 1);
        bus_stop();

        // R5: page write wraps inside the 64-byte page
        c0 = commits;
        begin_write(16'h013E, "R5");
        for (int n = 0; n < 4; n++) begin
            push_wr({7'(13'h013E >> 6), 6'(6'h3E + n)}, 8'(8'hC0 + n), "R5");
            put_byte(8'(8'hC0 + n), k);
            chk("R5 page byte ack", k, 1);
        end
        bus_stop();
        tick(4);
        chk("R6 one commit for page", commits - c0, 1);
        chk("R5 page wrapped byte stored", mem[13'h0100], 8'hC2);
        // R9: pointer one past last written location
        cur_read(13'h0102, "R9");

        // R10 / R6: random read of written location, dummy write commits nothing
        c0 = commits;
        rand_read(16'h0123, b, "R10");
        chk("R10 random read data", b, 8'h5A);
        tick(4);
        chk("R6 dummy write no commit", commits - c0, 0);

        // R9: wrap from top to zero
        rand_read(16'h1FFF, b, "R9");
        chk("R9 read of last location", b, mem[13'h1FFF]);
        cur_read(13'h0000, "R9 wrap");

        // R11: sequential read across the top, then release after no-ack
        begin_write(16'h1FFE, "R11");
        bus_start();
        put_byte(dev(1'b1), k);
        chk("R11 read select ack", k, 1);
        get_byte(1'b1, b); chk("R11 seq byte 0", b, mem[13'h1FFE]);
        get_byte(1'b1, b); chk("R11 seq byte 1", b, mem[13'h1FFF]);
        get_byte(1'b1, b); chk("R11 seq byte 2 wrapped", b, mem[13'h0000]);
        get_byte(1'b0, b); chk("R11 seq byte 3", b, mem[13'h0001]);
        r0 = oe_rises;
        for (int n = 0; n < 9; n++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            chk("R11 line free after no-ack", sda_line, 1);
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        chk("R11 no drive after no-ack", oe_rises - r0, 0);
        bus_stop();
        cur_read(13'h0002, "R11 pointer");

        // R8: protected quarter refuses first data byte
        wp = 1'b1;
        c0 = commits;
        w0 = wr_seen;
        orig = mem[13'h0010];
        begin_write(16'h0010, "R8");
        put_byte(8'h99, k);
        chk("R8 protected data no ack", k, 0);
        bus_stop();
        tick(4);
        chk("R8 no write strobe", wr_seen - w0, 0);
        chk("R8 no commit", commits - c0, 0);
        rand_read(16'h0010, b, "R8");
        chk("R8 contents kept", b, orig);
        c0 = commits;
        begin_write(16'h1000, "R8");
        push_wr(13'h1000, 8'h77, "R8");
        put_byte(8'h77, k);
        chk("R8 unprotected data ack", k, 1);
        bus_stop();
        tick(4);
        chk("R8 unprotected commit", commits - c0, 1);
        wp = 1'b0;

        // R12: start partway through a byte restarts framing
        bus_start();
        for (int i = 7; i >= 4; i--) begin
            sda_m = dev(1'b0)[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        cur_read(13'h1001, "R12");

        tick(20);
        chk("R4 scoreboard drained", exp_q.size(), 0);
        chk("R3 drive changed only with clock low", oe_bad, 0);
        finish_run();
    end

endmodule